// File: doc/BRIEF.md
# Single-Precision Float to Signed 32-bit Integer Converter

This block turns one IEEE-754 single-precision value into a signed 32-bit two's-complement integer. A 2-bit mode input picks the rounding direction for each sample. Alongside the integer it reports two exception flags. The invalid flag marks any input that has no 32-bit signed representation. The inexact flag marks any input whose fractional part was thrown away.

The block is a two-stage pipeline that accepts one sample every cycle. The first stage decodes the operand and aligns the significand to the integer point. It keeps one round bit and one sticky bit. The second stage applies the selected rounding, restores the sign, checks the range and registers the result. Every input that cannot be converted (NaN, either infinity, or a value too large in magnitude) returns the integer-indefinite pattern 0x80000000 with the invalid flag set.

Top module: `fp2int_round`

## Requirements
- R1: For in-range inputs the result follows `rnd_mode`: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward negative infinity, 2'b10 rounds toward positive infinity, 2'b11 truncates toward zero.
- R2: `out_inexact` is 1 exactly when the input is finite, representable after rounding, and has a nonzero fractional part; exact conversions leave it 0.
- R3: Any NaN input (exponent field bits 30:23 all ones, fraction bits 22:0 nonzero) gives `out_int` = 32'h80000000 with `out_invalid` = 1.
- R4: Positive or negative infinity (exponent all ones, fraction zero) gives 32'h80000000 with `out_invalid` = 1.
- R5: A finite input whose rounded value is 2^31 or more, or below -2^31, gives 32'h80000000 with `out_invalid` = 1.
- R6: An input of exactly -2^31 (32'hCF000000) converts to 32'h80000000 with both flags 0.
- R7: Zeros of either sign give 0 with no flags. Denormals and other magnitudes below 1 give 0, -1 or +1 according to sign and mode.
- R8: `out_invalid` and `out_inexact` are never 1 together.
- R9: `out_valid` is `in_valid` delayed by exactly two clock cycles, and each result appears together with its own `out_valid`. A new sample is accepted every cycle.
- R10: While `rst_n` is low and after it is released, `out_valid`, `out_int`, `out_invalid` and `out_inexact` are all 0 until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_f | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | Rounding mode select (see R1) |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision (inexact) flag |

## Verification
The bench targets the tie cases under nearest-even. These are 0.5, 1.5, 2.5 and their negatives. A design that rounded half away from zero would return 3 for 2.5 instead of 2. It also drives denormals and tiny values under the directed modes. A converter that dropped the sticky bits would return 0 where -1 or +1 is expected, and would leave inexact clear. The edge at 2^31 gets its own cases: -2^31 must pass cleanly, while +2^31 and the next negative value below -2^31 must be rejected. An off-by-one exponent limit would either flag -2^31 or wrap +2^31 into a negative number. Random operands are sent back to back with gaps in the strobe, which exposes a result that leaves the pipeline on the wrong cycle.

// File: rtl/fp2int_round.sv
module fp2int_round #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_f,
  input  logic [1:0]   rnd_mode,
  output logic         out_valid,
  output logic [W-1:0] out_int,
  output logic         out_invalid,
  output logic         out_inexact
);
  localparam int MW     = 24;
  localparam int BIAS_I = 150;
  localparam int MAXSH  = 26;
  localparam logic [W-1:0] INDEF = {1'b1, {(W-1){1'b0}}};

  logic        sgn;
  logic [7:0]  ex;
  logic [MW-1:0] man;
  logic        big;
  logic [7:0]  rsh_raw;
  logic [4:0]  rsh;
  logic [3:0]  lsh;
  logic [MW+MAXSH-1:0] algn;
  logic        bad_in;

  assign sgn     = in_f[31];
  assign ex      = in_f[30:23];
  assign man     = {ex != 8'd0, in_f[22:0]};
  assign big     = ex >= 8'(BIAS_I);
  assign rsh_raw = 8'(BIAS_I) - ex;
  assign rsh     = (rsh_raw > 8'(MAXSH)) ? 5'(MAXSH) : rsh_raw[4:0];
  assign lsh     = 4'(ex - 8'(BIAS_I));
  assign algn    = {man, {MAXSH{1'b0}}} >> rsh;
  assign bad_in  = (ex == 8'hFF) || (ex > 8'd158) ||
                   (ex == 8'd158 && !(sgn && in_f[22:0] == 23'd0));

  logic         s1_v, s1_s, s1_bad, s1_rb, s1_st;
  logic [1:0]   s1_md;
  logic [W-1:0] s1_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_s   <= 1'b0;
      s1_bad <= 1'b0;
      s1_rb  <= 1'b0;
      s1_st  <= 1'b0;
      s1_md  <= 2'b00;
      s1_mag <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_s   <= sgn;
        s1_bad <= bad_in;
        s1_md  <= rnd_mode;
        s1_mag <= big ? ({8'd0, man} << lsh) : {8'd0, algn[MW+MAXSH-1:MAXSH]};
        s1_rb  <= big ? 1'b0 : algn[MAXSH-1];
        s1_st  <= big ? 1'b0 : |algn[MAXSH-2:0];
      end
    end
  end

  logic         lossy, bump, ovf, inv2;
  logic [W-1:0] rmag, sres;

  assign lossy = s1_rb | s1_st;

  always_comb begin
    case (s1_md)
      2'b00:   bump = s1_rb & (s1_st | s1_mag[0]);
      2'b01:   bump = s1_s & lossy;
      2'b10:   bump = ~s1_s & lossy;
      default: bump = 1'b0;
    endcase
  end

  assign rmag = s1_mag + W'(bump);
  assign ovf  = s1_s ? (rmag[W-1] && |rmag[W-2:0]) : rmag[W-1];
  assign inv2 = s1_bad | ovf;
  assign sres = s1_s ? (~rmag + 1'b1) : rmag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_int     <= inv2 ? INDEF : sres;
        out_invalid <= inv2;
        out_inexact <= ~inv2 & lossy;
      end
    end
  end
endmodule

module fp2int_round_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_f,
  input logic [1:0]  rnd_mode,
  input logic        out_valid,
  input logic [31:0] out_int,
  input logic        out_invalid,
  input logic        out_inexact
);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  a_r5_invalid_indef: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_int == 32'h80000000);

  a_r9_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r9_idle_lat: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  a_r3_nan_inf_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_f[30:23] == 8'hFF) |=> ##1 (out_invalid && out_int == 32'h80000000));

  a_r7_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_f[30:0] == 31'd0) |=> ##1 (out_int == 32'd0 && !out_invalid && !out_inexact));

  a_r6_min_int_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_f == 32'hCF000000) |=> ##1 (out_int == 32'h80000000 && !out_invalid && !out_inexact));
endmodule

bind fp2int_round fp2int_round_chk u_chk (.*);

// File: tb/sim_fp2int_round.sv
module sim_fp2int_round;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_f = '0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_invalid, out_inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fp2int_round u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [33:0] ref_cvt(input logic [31:0] f, input logic [1:0] md);
    logic s; int e; logic [23:0] m; logic [63:0] fx;
    longint ip, v; logic [31:0] fr; bit up, tiny, nz;
    s = f[31]; e = int'(f[30:23]); m = {e != 0, f[22:0]};
    if (e == 255) return {2'b10, 32'h80000000};
    if (e > 157) begin
      if (f == 32'hCF000000) return {2'b00, 32'h80000000};
      return {2'b10, 32'h80000000};
    end
    if (e >= 118) begin
      fx = {40'd0, m} << (e - 118);
      ip = longint'(fx[63:32]); fr = fx[31:0]; tiny = 0;
    end else begin
      ip = 0; fr = 0; tiny = (m != 0);
    end
    nz = tiny || fr != 0;
    case (md)
      2'b00:   up = !tiny && (fr > 32'h80000000 || (fr == 32'h80000000 && ip[0]));
      2'b01:   up = s && nz;
      2'b10:   up = !s && nz;
      default: up = 0;
    endcase
    ip = ip + longint'(up);
    v = s ? -ip : ip;
    if (v > 64'sd2147483647 || v < -64'sd2147483648) return {2'b10, 32'h80000000};
    return {1'b0, nz, v[31:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] f, input logic [33:0] r);
    if (f[30:23] == 8'hFF) return (f[22:0] != 0) ? "R3" : "R4";
    if (f == 32'hCF000000) return "R6";
    if (r[33]) return "R5";
    if (f[30:23] < 8'd127) return "R7";
    if (r[32]) return "R2";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tg, act, exp);
    end
  endtask

  logic [33:0] pexp [2];
  logic [31:0] pf   [2];
  bit          pv   [2];

  task automatic step(input bit v, input logic [31:0] f, input logic [1:0] md);
    @(negedge clk);
    check(out_valid == pv[1], "R9", {63'd0, out_valid}, {63'd0, pv[1]});
    if (pv[1]) begin
      check({out_invalid, out_inexact, out_int} == pexp[1], tag_of(pf[1], pexp[1]),
            {30'd0, out_invalid, out_inexact, out_int}, {30'd0, pexp[1]});
      if (out_invalid || out_inexact)
        check(!(out_invalid && out_inexact), "R8", {62'd0, out_invalid, out_inexact}, 64'd0);
    end
    pv[1] = pv[0]; pexp[1] = pexp[0]; pf[1] = pf[0];
    pv[0] = v; pexp[0] = ref_cvt(f, md); pf[0] = f;
    in_valid = v; in_f = f; rnd_mode = md;
  endtask

  function automatic logic [31:0] rand_f();
    logic [7:0] e;
    int sel = int'($urandom_range(0, 9));
    if (sel < 5)       e = 8'($urandom_range(120, 160));
    else if (sel < 7)  e = 8'($urandom_range(154, 160));
    else if (sel < 8)  e = 8'($urandom_range(0, 2));
    else if (sel < 9)  e = 8'hFF;
    else               e = 8'($urandom_range(0, 255));
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    logic [31:0] dir [18];
    void'($urandom(32'd20240611));
    dir = '{32'h00000000, 32'h80000000, 32'h3F800000, 32'h3FC00000,
            32'h40200000, 32'hC0200000, 32'h3F000000, 32'hBF000000,
            32'h00000001, 32'h80000001, 32'h7FC00000, 32'hFF800001,
            32'h7F800000, 32'hFF800000, 32'hCF000000, 32'h4F000000,
            32'h4EFFFFFF, 32'hCF000001};
    pv = '{0, 0};
    pexp = '{34'd0, 34'd0};
    pf = '{32'd0, 32'd0};
    repeat (3) @(negedge clk);
    // R10: state during and right after reset
    check(!out_valid && out_int == 0 && !out_invalid && !out_inexact, "R10",
          {30'd0, out_valid, out_invalid, out_int}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && out_int == 0 && !out_invalid && !out_inexact, "R10",
          {30'd0, out_valid, out_invalid, out_int}, 64'd0);
    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 18; i++) step(1'b1, dir[i], 2'(md));
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) != 0, rand_f(), 2'($urandom));
    step(1'b0, 32'd0, 2'd0);
    step(1'b0, 32'd0, 2'd0);
    step(1'b0, 32'd0, 2'd0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule